// File: doc/BRIEF.md
# Wait-State Bus Cycle Controller

This block paces each processor bus access. A cycle runs in three phases: the processor offers an address with a strobe, the controller holds the cycle open while a region-specific wait elapses, and a termination step ends it. The target region comes from four decode inputs.

Three regions have fixed waits, set by parameters: main memory takes none, the video shifter takes one and the EEPROM takes four. The I/O region is open-ended. Its cycle lasts until the peripheral acknowledges, or until a timeout ends it and sets a sticky error flag.

The processor sees a single ready pulse when its access is done. The addressed device sees a one-hot chip strobe for as long as the access lasts. Back-pressure is the wait itself: a new strobe is taken only while the controller is idle. A request presented earlier simply finds no taker and has no effect. The processor keeps its strobe up, or presents it again, until it sees ready.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, `cpu_ready` is 0, `chip_sel` is all zero and `bus_error` is 0.
- R2: A cycle starts only in idle, at a clock edge where `addr_strobe` is 1 and at least one `region_sel` bit is 1. The chip strobe appears in the cycle after that edge. A strobe with no region bit starts nothing, and changes to `addr_strobe` or `region_sel` during a running cycle have no effect on it.
- R3: When several `region_sel` bits are set, the lowest index wins: bit 0 main memory, then bit 1 video, then bit 2 EEPROM, then bit 3 I/O. `chip_sel` uses the same bit positions and has at most one bit set.
- R4: A main-memory access holds `chip_sel[0]` for exactly 1 clock.
- R5: A video access holds `chip_sel[1]` for exactly 2 clocks (one wait state).
- R6: An EEPROM access holds `chip_sel[2]` for exactly 5 clocks (four wait states).
- R7: An I/O access holds `chip_sel[3]` until the acknowledge, passed through a two-flop synchronizer, is seen. If `periph_ack` is first sampled high at the k-th strobe clock, the strobe lasts k+2 clocks.
- R8: An I/O access with no acknowledge holds `chip_sel[3]` for 256 clocks, then terminates and sets `bus_error`. `bus_error` stays set until reset.
- R9: After each access's strobe, `cpu_ready` is 1 for exactly one clock with `chip_sel` all zero. The next cycle's strobe can be accepted only after that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_strobe | input | 1 | Address-valid strobe from the processor |
| region_sel | input | 4 | Region decodes: bit 0 memory, 1 video, 2 EEPROM, 3 I/O |
| periph_ack | input | 1 | Asynchronous completion from the I/O device |
| cpu_ready | output | 1 | One-clock end-of-access pulse to the processor |
| chip_sel | output | 4 | One-hot chip strobe for the active region |
| bus_error | output | 1 | Sticky flag: an I/O access timed out |

## Verification
A wrong wait counter or phase register shows up at the ports at once as a chip strobe that is too long or too short. It is caught on the first clock where the strobe width or the ready pulse departs from the per-region count. A wrong latched region shows as the wrong `chip_sel` bit one clock after acceptance. A broken synchronizer or timeout counter moves the ready pulse of an I/O access away from its expected clock. It can also leave `bus_error` in the wrong state, which then stays visible for the rest of the run.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int IO_IDX      = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_TERM   = 2'd2
  } bus_phase_t;
endpackage

// File: rtl/bwc_sync.sv
module bwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bwc_prio_sel.sv
module bwc_prio_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;
  generate
    for (genvar i = 0; i < N; i++) begin : g_rank
      assign grant[i]   = req[i] & ~taken[i];
      assign taken[i+1] = taken[i] | req[i];
    end
  endgenerate
endmodule

// File: rtl/bwc_wait_cnt.sv
module bwc_wait_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int RAM_WAITS  = 0,
  parameter int VID_WAITS  = 1,
  parameter int ROM_WAITS  = 4,
  parameter int IO_TIMEOUT = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_strobe,
  input  logic [NUM_REGIONS-1:0] region_sel,
  input  logic                   periph_ack,
  output logic                   cpu_ready,
  output logic [NUM_REGIONS-1:0] chip_sel,
  output logic                   bus_error
);
  localparam int MAXW_A = (RAM_WAITS > VID_WAITS) ? RAM_WAITS : VID_WAITS;
  localparam int MAXW   = (MAXW_A > ROM_WAITS) ? MAXW_A : ROM_WAITS;
  localparam int WAIT_W = (MAXW > 0) ? $clog2(MAXW + 1) : 1;
  localparam int TO_W   = (IO_TIMEOUT > 2) ? $clog2(IO_TIMEOUT) : 1;

  bus_phase_t             phase;
  logic [NUM_REGIONS-1:0] grant;
  logic [NUM_REGIONS-1:0] active;
  logic [WAIT_W-1:0]      load_val;
  logic [TO_W-1:0]        to_cnt;
  logic                   ack_s;
  logic                   start;
  logic                   wait_done;
  logic                   to_last;

  bwc_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(periph_ack), .q_sync(ack_s)
  );

  bwc_prio_sel #(.N(NUM_REGIONS)) u_prio (
    .req(region_sel), .grant(grant)
  );

  always_comb begin
    load_val = '0;
    if (grant[0])      load_val = WAIT_W'(RAM_WAITS);
    else if (grant[1]) load_val = WAIT_W'(VID_WAITS);
    else if (grant[2]) load_val = WAIT_W'(ROM_WAITS);
  end

  assign start   = (phase == PH_IDLE) && addr_strobe && (|region_sel);
  assign to_last = (to_cnt == TO_W'(IO_TIMEOUT - 1));

  bwc_wait_cnt #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(load_val),
    .dec(phase == PH_ACCESS), .is_zero(wait_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      active    <= '0;
      to_cnt    <= '0;
      bus_error <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_ACCESS;
            active <= grant;
            to_cnt <= '0;
          end
        end
        PH_ACCESS: begin
          if (active[IO_IDX]) begin
            if (ack_s) begin
              phase <= PH_TERM;
            end else if (to_last) begin
              phase     <= PH_TERM;
              bus_error <= 1'b1;
            end else begin
              to_cnt <= to_cnt + 1'b1;
            end
          end else if (wait_done) begin
            phase <= PH_TERM;
          end
        end
        PH_TERM: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign chip_sel  = (phase == PH_ACCESS) ? active : '0;
  assign cpu_ready = (phase == PH_TERM);
endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk #(
  parameter int ROM_WAITS  = 4,
  parameter int IO_TIMEOUT = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic [3:0] chip_sel,
  input logic       bus_error
);
  logic [15:0] rom_run;
  logic [15:0] io_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_run <= '0;
      io_run  <= '0;
    end else begin
      rom_run <= chip_sel[2] ? rom_run + 1'b1 : '0;
      io_run  <= chip_sel[3] ? io_run + 1'b1 : '0;
    end
  end

  a_r3_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chip_sel));

  a_r4_ram_single: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel[0] |=> (cpu_ready && !chip_sel[0]));

  a_r5_video_two: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel[1] && $past(chip_sel[1])) |=> cpu_ready);

  a_r6_rom_five: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel[2] && rom_run == 16'(ROM_WAITS)) |=> cpu_ready);

  a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel[3] && io_run == 16'(IO_TIMEOUT - 1)) |=> (cpu_ready && bus_error));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |=> bus_error);

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r9_ready_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (chip_sel == 4'b0000));
endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk u_chk (.*);

// File: tb/bus_wait_ctrl_test.sv
`timescale 1ns/1ps
module bus_wait_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_strobe = 1'b0;
  logic [3:0] region_sel = 4'b0000;
  logic       periph_ack = 1'b0;
  logic       cpu_ready;
  logic [3:0] chip_sel;
  logic       bus_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_wait_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .region_sel(region_sel),
    .periph_ack(periph_ack), .cpu_ready(cpu_ready), .chip_sel(chip_sel),
    .bus_error(bus_error)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 access, 2 ready
  int m_phase = 0, m_reg = 0, m_left = 0, m_elapsed = 0;
  bit m_err = 0;
  bit q1 = 0, q2 = 0;
  int waits[3] = '{0, 1, 4};

  always @(posedge clk) begin
    bit nq1, nq2;
    nq1 = periph_ack;
    nq2 = q1;
    if (!rst_n) begin
      m_phase = 0; m_err = 0; nq1 = 0; nq2 = 0;
    end else begin
      case (m_phase)
        0: if (addr_strobe && region_sel != 0) begin
             for (int i = 3; i >= 0; i--) if (region_sel[i]) m_reg = i;
             if (m_reg < 3) m_left = waits[m_reg];
             m_elapsed = 0;
             m_phase = 1;
           end
        1: if (m_reg == 3) begin
             if (q2) m_phase = 2;
             else if (m_elapsed == 255) begin m_phase = 2; m_err = 1; end
             else m_elapsed++;
           end else if (m_left == 0) m_phase = 2;
           else m_left--;
        default: m_phase = 0;
      endcase
    end
    q1 = nq1;
    q2 = nq2;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_sel;
      exp_sel = (m_phase == 1) ? (1 << m_reg) : 0;
      check(chip_sel == 4'(exp_sel), (m_reg == 3) ? "R7 model strobe" : "R4 model strobe",
            chip_sel, exp_sel);
      check(cpu_ready == (m_phase == 2), "R9 model ready", cpu_ready, m_phase == 2);
      check(bus_error == m_err, "R8 model error", bus_error, m_err);
    end
  end

  task automatic run_cycle(input logic [3:0] sel, input int ack_at, input bit keep,
                           output int held, output logic [3:0] first);
    @(negedge clk);
    addr_strobe = 1'b1;
    region_sel  = sel;
    held = 0;
    first = 4'b0000;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (keep) region_sel = 4'b0001;
      else begin addr_strobe = 1'b0; region_sel = 4'b0000; end
      if (chip_sel != 0) begin
        held++;
        if (held == 1) first = chip_sel;
        if (held == ack_at) periph_ack = 1'b1;
      end
      if (cpu_ready) begin
        check(chip_sel == 4'b0000, "R9 strobe off at ready", chip_sel, 0);
        addr_strobe = 1'b0;
        region_sel  = 4'b0000;
        periph_ack  = 1'b0;
        break;
      end
    end
    @(negedge clk);
    check(cpu_ready == 1'b0, "R9 ready one clock", cpu_ready, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int h;
    logic [3:0] f;
    repeat (3) @(negedge clk);
    check(cpu_ready == 0, "R1 ready reset", cpu_ready, 0);
    check(chip_sel == 0, "R1 strobe reset", chip_sel, 0);
    check(bus_error == 0, "R1 error reset", bus_error, 0);
    rst_n = 1'b1;

    run_cycle(4'b0001, -1, 0, h, f);
    check(h == 1, "R4 memory strobe length", h, 1);
    run_cycle(4'b0010, -1, 0, h, f);
    check(h == 2, "R5 video strobe length", h, 2);
    run_cycle(4'b0100, -1, 0, h, f);
    check(h == 5, "R6 eeprom strobe length", h, 5);

    run_cycle(4'b1110, -1, 0, h, f);
    check(f == 4'b0010, "R3 video over eeprom and io", f, 4'b0010);
    run_cycle(4'b1100, -1, 0, h, f);
    check(f == 4'b0100, "R3 eeprom over io", f, 4'b0100);
    run_cycle(4'b1111, -1, 0, h, f);
    check(f == 4'b0001, "R3 memory over all", f, 4'b0001);

    run_cycle(4'b1000, 1, 0, h, f);
    check(h == 3, "R7 io ack at first clock", h, 3);
    run_cycle(4'b1000, 10, 0, h, f);
    check(h == 12, "R7 io ack at tenth clock", h, 12);

    run_cycle(4'b0100, -1, 1, h, f);
    check(h == 5 && f == 4'b0100, "R2 mid-cycle inputs ignored", h, 5);
    @(negedge clk);
    addr_strobe = 1'b1;
    region_sel  = 4'b0000;
    @(negedge clk);
    addr_strobe = 1'b0;
    check(chip_sel == 0, "R2 strobe without region", chip_sel, 0);
    @(negedge clk);

    check(bus_error == 0, "R8 no error before timeout", bus_error, 0);
    run_cycle(4'b1000, -1, 0, h, f);
    check(h == 256, "R8 timeout strobe length", h, 256);
    check(bus_error == 1, "R8 error raised", bus_error, 1);
    run_cycle(4'b0001, -1, 0, h, f);
    check(bus_error == 1, "R8 error sticky", bus_error, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule